// File: doc/BRIEF.md
# Hysteretic Digital Lock Detector

This block decides whether a phase-locked loop has settled by watching the two correction pulses of its phase detector, UP and DOWN, on a fast sampling clock. Each phase-detector period ends with a one-tick strobe. The phase error of that period is the number of fast-clock ticks in which exactly one of UP or DOWN was high. The count starts on the tick after the previous strobe and runs through the strobe tick itself. Ticks where both pulses are high, or both are low, add nothing.

A small state machine has two states, `ST_ACQUIRE` and `ST_LOCKED`. In `ST_ACQUIRE` it counts a run of consecutive periods whose error is below a lock threshold. The run needed is three periods, or five when the precision input is high. When the run is complete it takes the transition *acquire-to-locked*. In `ST_LOCKED` it stays put until one period shows an error above a separate, larger release threshold. That period causes the transition *locked-to-acquire*, which also clears the run counter. Errors between the two thresholds therefore keep an existing lock but never build a new one.

The lock flag is registered and is updated only on strobe ticks. Both thresholds are parameters given in fast-clock ticks. The defaults of 15 and 25 ticks correspond to 15 ns and 25 ns at a 1 ns sampling clock.

Top module: `phase_lock_monitor`

## Requirements
- R1: `locked_o` is active high. Reset drives it low and clears the run counter, so a full run is needed again after reset.
- R2: With `strict_i` = 0 at the strobes, three consecutive periods with error below `LOCK_TH` (error <= 14 at defaults) set `locked_o` high on the clock edge that samples the third strobe.
- R3: With `strict_i` = 1 at the strobes, five consecutive such periods are needed. After only three or four of them, `locked_o` is still low.
- R4: While unlocked, any period with error >= `LOCK_TH` (15 at defaults) resets the run counter to zero. A new run then starts from the next period.
- R5: While locked, a period with error > `UNLOCK_TH` (26 or more at defaults) drives `locked_o` low on the edge that samples its strobe.
- R6: While locked, a period with error from `LOCK_TH` to `UNLOCK_TH` inclusive (15..25 at defaults) has no effect: `locked_o` stays high.
- R7: The error of a period counts the ticks with `up_i` XOR `dn_i` = 1, from the tick after the previous strobe through the strobe tick. Ticks with both inputs high add zero.
- R8: The error count saturates at 2^CNT_W-1 (31 at defaults) instead of wrapping. A locked period with 40 error ticks therefore still releases lock.
- R9: `locked_o` changes only on the clock edge that samples `cycle_strobe_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_i | input | 1 | UP pulse from the phase detector |
| dn_i | input | 1 | DOWN pulse from the phase detector |
| cycle_strobe_i | input | 1 | One-tick marker on the last tick of each detector period |
| strict_i | input | 1 | 0: three-period run, 1: five-period run |
| locked_o | output | 1 | Lock flag, high when locked |

## Verification
The hardest state to reach from the ports is a held lock facing an error exactly at a boundary value: 14 against 15 to build a run, 25 against 26 to release it. A saturated count is equally hard to reach, because it needs a detector period longer than the counter range with almost every tick in error. The bench gets there by first building a lock with directed runs of zero-error periods. It then applies single periods with exact error counts of 14, 15, 25, 26 and 40, padding the error-free ticks with both-high pulses. After that, a seeded random sequence mixes period lengths, near-threshold errors and precision changes, and a reference model tracks the expected flag.

// File: rtl/plm_pkg.sv
package plm_pkg;

    typedef enum logic [1:0] {
        VERDICT_SMALL = 2'd0,
        VERDICT_MID   = 2'd1,
        VERDICT_LARGE = 2'd2
    } verdict_t;

    typedef enum logic {
        ST_ACQUIRE = 1'b0,
        ST_LOCKED  = 1'b1
    } lock_state_t;

endpackage

// File: rtl/plm_error_meter.sv
module plm_error_meter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_i,
    input  logic             dn_i,
    input  logic             strobe_i,
    output logic [CNT_W-1:0] err_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] acc_q;
    logic             mismatch;

    assign mismatch = up_i ^ dn_i;

    // Saturating sum that includes the current tick
    always_comb begin
        if (acc_q == CNT_MAX) begin
            err_o = acc_q;
        end else begin
            err_o = acc_q + {{(CNT_W-1){1'b0}}, mismatch};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (strobe_i) begin
            acc_q <= '0;
        end else begin
            acc_q <= err_o;
        end
    end

    // R8: between strobes the count never goes down (no wrap)
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> acc_q >= $past(acc_q));

endmodule

// File: rtl/plm_error_classifier.sv
module plm_error_classifier
    import plm_pkg::*;
#(
    parameter int CNT_W     = 5,
    parameter int LOCK_TH   = 15,
    parameter int UNLOCK_TH = 25
) (
    input  logic [CNT_W-1:0] err_i,
    output verdict_t         verdict_o
);
    localparam logic [CNT_W-1:0] LOCK_LIM   = CNT_W'(LOCK_TH);
    localparam logic [CNT_W-1:0] UNLOCK_LIM = CNT_W'(UNLOCK_TH);

    always_comb begin
        if (err_i < LOCK_LIM) begin
            verdict_o = VERDICT_SMALL;
        end else if (err_i > UNLOCK_LIM) begin
            verdict_o = VERDICT_LARGE;
        end else begin
            verdict_o = VERDICT_MID;
        end
    end

endmodule

// File: rtl/plm_lock_fsm.sv
module plm_lock_fsm
    import plm_pkg::*;
#(
    parameter int RUN_LOOSE  = 3,
    parameter int RUN_STRICT = 5
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     valid_i,
    input  verdict_t verdict_i,
    input  logic     strict_i,
    output logic     locked_o
);
    localparam int RUN_MAX = (RUN_STRICT > RUN_LOOSE) ? RUN_STRICT : RUN_LOOSE;
    localparam int RUN_W   = $clog2(RUN_MAX + 1);

    lock_state_t      state_q, state_d;
    logic [RUN_W-1:0] run_q, run_d;
    logic [RUN_W:0]   run_inc;
    logic [RUN_W:0]   run_need;

    assign run_inc  = {1'b0, run_q} + {{RUN_W{1'b0}}, 1'b1};
    assign run_need = strict_i ? (RUN_W+1)'(RUN_STRICT) : (RUN_W+1)'(RUN_LOOSE);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        unique case (state_q)
            ST_ACQUIRE: begin
                if (valid_i) begin
                    if (verdict_i == VERDICT_SMALL) begin
                        if (run_inc >= run_need) begin
                            state_d = ST_LOCKED;      // acquire-to-locked
                            run_d   = '0;
                        end else begin
                            run_d   = run_inc[RUN_W-1:0];
                        end
                    end else begin
                        run_d = '0;
                    end
                end
            end
            ST_LOCKED: begin
                if (valid_i && (verdict_i == VERDICT_LARGE)) begin
                    state_d = ST_ACQUIRE;             // locked-to-acquire
                    run_d   = '0;
                end
            end
            default: begin
                state_d = ST_ACQUIRE;
                run_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ACQUIRE;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    // Outputs
    always_comb begin
        locked_o = (state_q == ST_LOCKED);
    end

    a_r9_flag_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(locked_o));

    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && valid_i && verdict_i == VERDICT_LARGE) |=> !locked_o);

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && valid_i && verdict_i != VERDICT_LARGE) |=> locked_o);

    a_r4_run_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked_o && valid_i && verdict_i != VERDICT_SMALL) |=> (run_q == '0 && !locked_o));

    a_r1_rise_on_small: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(valid_i && verdict_i == VERDICT_SMALL));

endmodule

// File: rtl/phase_lock_monitor.sv
module phase_lock_monitor
    import plm_pkg::*;
#(
    parameter int LOCK_TH    = 15,
    parameter int UNLOCK_TH  = 25,
    parameter int RUN_LOOSE  = 3,
    parameter int RUN_STRICT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic up_i,
    input  logic dn_i,
    input  logic cycle_strobe_i,
    input  logic strict_i,
    output logic locked_o
);
    localparam int CNT_W = $clog2(UNLOCK_TH + 2);

    logic [CNT_W-1:0] period_err;
    verdict_t         verdict;

    plm_error_meter #(
        .CNT_W (CNT_W)
    ) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_i     (up_i),
        .dn_i     (dn_i),
        .strobe_i (cycle_strobe_i),
        .err_o    (period_err)
    );

    plm_error_classifier #(
        .CNT_W     (CNT_W),
        .LOCK_TH   (LOCK_TH),
        .UNLOCK_TH (UNLOCK_TH)
    ) u_classify (
        .err_i     (period_err),
        .verdict_o (verdict)
    );

    plm_lock_fsm #(
        .RUN_LOOSE  (RUN_LOOSE),
        .RUN_STRICT (RUN_STRICT)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (cycle_strobe_i),
        .verdict_i (verdict),
        .strict_i  (strict_i),
        .locked_o  (locked_o)
    );

endmodule

// File: tb/phase_lock_monitor_test.sv
`timescale 1ns/1ps
module phase_lock_monitor_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up_i = 1'b0;
    logic dn_i = 1'b0;
    logic cycle_strobe_i = 1'b0;
    logic strict_i = 1'b0;
    logic locked_o;

    int n_checks = 0;
    int n_fails  = 0;
    int m_locked = 0;
    int m_run    = 0;
    bit done     = 1'b0;

    localparam int SAT_MAX = 31;

    always #2 clk = ~clk;

    phase_lock_monitor uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .up_i           (up_i),
        .dn_i           (dn_i),
        .cycle_strobe_i (cycle_strobe_i),
        .strict_i       (strict_i),
        .locked_o       (locked_o)
    );

    function automatic int sat_err(input int e);
        return (e > SAT_MAX) ? SAT_MAX : e;
    endfunction

    // Reference update for one completed period
    function automatic void model_step(input int e, input bit strict);
        int need;
        need = strict ? 5 : 3;
        if (m_locked == 0) begin
            if (e < 15) begin
                m_run++;
                if (m_run >= need) begin
                    m_locked = 1;
                    m_run = 0;
                end
            end else begin
                m_run = 0;
            end
        end else if (e > 25) begin
            m_locked = 0;
            m_run = 0;
        end
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: locked_o=%0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One detector period: len ticks, err of them with exactly one pulse high
    task automatic run_period(input int len, input int err, input bit strict,
                              input bit fill_high, input string req);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            strict_i = strict;
            cycle_strobe_i = (i == len - 1);
            if (i < err) begin
                if ($urandom_range(1, 0) == 1) begin
                    up_i = 1'b1; dn_i = 1'b0;
                end else begin
                    up_i = 1'b0; dn_i = 1'b1;
                end
            end else begin
                up_i = fill_high; dn_i = fill_high;
            end
            if (i != len - 1) begin
                if (i > 0) check({req, "/R9"}, int'(locked_o), m_locked);
            end
        end
        @(negedge clk);
        cycle_strobe_i = 1'b0;
        up_i = 1'b0; dn_i = 1'b0;
        model_step(sat_err(err), strict);
        check(req, int'(locked_o), m_locked);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cycle_strobe_i = 1'b0; up_i = 1'b0; dn_i = 1'b0;
        repeat (3) @(negedge clk);
        m_locked = 0;
        m_run = 0;
        check("R1 reset", int'(locked_o), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd4242));
        do_reset();

        // R2: three small periods in loose mode
        run_period(20, 0, 1'b0, 1'b0, "R2 first");
        run_period(20, 14, 1'b0, 1'b1, "R2 second");
        run_period(20, 5, 1'b0, 1'b0, "R2 third");
        check("R2 lock set", int'(locked_o), 1);

        // R6: mid-band errors keep lock
        run_period(30, 15, 1'b0, 1'b0, "R6 err15");
        run_period(30, 25, 1'b0, 1'b1, "R6 err25");
        check("R6 held", int'(locked_o), 1);

        // R5: 26 releases
        run_period(30, 26, 1'b0, 1'b0, "R5 err26");
        check("R5 released", int'(locked_o), 0);

        // R3: strict needs five
        for (int k = 0; k < 4; k++) run_period(18, 3, 1'b1, 1'b0, "R3 partial");
        check("R3 not yet", int'(locked_o), 0);
        run_period(18, 0, 1'b1, 1'b1, "R3 fifth");
        check("R3 lock set", int'(locked_o), 1);

        // R8: 40 error ticks saturate and release
        run_period(45, 40, 1'b0, 1'b0, "R8 saturate");
        check("R8 released", int'(locked_o), 0);

        // R4: an err of 15 in the middle of a run restarts it
        run_period(20, 2, 1'b0, 1'b0, "R4 a");
        run_period(20, 2, 1'b0, 1'b0, "R4 b");
        run_period(20, 15, 1'b0, 1'b0, "R4 break");
        run_period(20, 2, 1'b0, 1'b0, "R4 c");
        run_period(20, 2, 1'b0, 1'b0, "R4 d");
        check("R4 still unlocked", int'(locked_o), 0);
        run_period(20, 2, 1'b0, 1'b0, "R4 e");
        check("R4 lock after new run", int'(locked_o), 1);

        // R7: both-high ticks add nothing, long period of overlap
        run_period(60, 0, 1'b0, 1'b1, "R7 overlap");
        check("R7 held", int'(locked_o), 1);

        // R1: reset while locked, full run needed again
        do_reset();
        run_period(20, 0, 1'b0, 1'b0, "R1 a");
        run_period(20, 0, 1'b0, 1'b0, "R1 b");
        check("R1 no early lock", int'(locked_o), 0);

        // Random mix
        for (int k = 0; k < 400; k++) begin
            int len;
            int err;
            int pick;
            bit strict;
            len = $urandom_range(60, 16);
            pick = $urandom_range(9, 0);
            case (pick)
                0: err = 14;
                1: err = 15;
                2: err = 25;
                3: err = 26;
                4: err = $urandom_range(len, 27);
                default: err = $urandom_range(10, 0);
            endcase
            if (err > len) err = len;
            strict = ($urandom_range(7, 0) == 0) ? ~strict_i : strict_i;
            run_period(len, err, strict, $urandom_range(1, 0) == 1, "R7 random");
        end

        done = 1'b1;
    end

    initial begin
        int ticks;
        ticks = 0;
        while (!done && ticks < 150000) begin
            @(posedge clk);
            ticks++;
        end
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule